// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block supplies the address for four-beat bursts into a synchronous memory. A new operation captures an external word address. On each following advance cycle the two least significant address bits step to the next beat of the burst, and the upper bits stay as they were captured. Because the counter is two bits wide, every burst stays inside the aligned group of four words that holds its starting word.

A static ordering input selects one of two beat orders. The interleaved order XORs the captured start offset with a beat count. The linear order adds the beat count to the start offset, modulo four. Either order can begin at any of the four offsets. An active-high stall input freezes all state, and the sequencer then continues from the same point once the stall is removed. The reset input is asynchronous and active low. Its release passes through a two-stage synchronizer before the registers leave reset.

Top module: `burst_addr_seq`

## Requirements
- R1: While the internal reset is asserted, `burst_addr` is all zeros.
- R2: On an edge with `stall`=0 and `adv`=0, the whole of `ext_addr` is captured, and after that edge `burst_addr` equals it (beat 0).
- R3: With `interleave`=1, beat k of a burst has low bits `start XOR k`. From 00 the order is 00,01,10,11; from 01 it is 01,00,11,10; from 10 it is 10,11,00,01; from 11 it is 11,10,01,00.
- R4: With `interleave`=0, beat k of a burst has low bits `(start + k) mod 4`. For example, from 01 the order is 01,10,11,00.
- R5: Advance cycles (`adv`=1, `stall`=0) never change `burst_addr[ADDR_W-1:2]`, and `ext_addr` is ignored on those cycles.
- R6: The fourth advance after a load brings the low bits back to the start value, without any flag.
- R7: On an edge with `stall`=1, `burst_addr` keeps its value whatever `adv` and `ext_addr` are. When the stall ends, the sequence continues from the beat where it stopped.
- R8: A load in the middle of a burst abandons that burst and starts a new one at beat 0 from the new address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized |
| stall | input | 1 | 1 freezes all state on this edge |
| adv | input | 1 | 0 captures `ext_addr`, 1 steps to the next beat |
| interleave | input | 1 | Static order select: 1 interleaved, 0 linear |
| ext_addr | input | ADDR_W | External word address |
| burst_addr | output | ADDR_W | Current burst address: captured upper bits and the two sequenced low bits |

## Verification
The hardest case to reach is a stall that falls in the middle of a burst while `adv` is high and `ext_addr` carries a different address. In that case a faulty design would either step to the next beat or capture the new address. The stimulus first loads a start offset and advances one beat. It then holds `stall` high for several edges with those misleading inputs, and then resumes advancing. The bench checks that the remaining beats continue the original order and wrap back to the original start.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  localparam int BEAT_W = 2;
  typedef logic [BEAT_W-1:0] beat_t;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_STEP = 2'd2
  } seq_op_e;
endpackage

// File: rtl/bseq_rst_sync.sv
module bseq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/bseq_ctrl.sv
module bseq_ctrl
  import bseq_pkg::*;
(
  input  logic    stall,
  input  logic    adv,
  output seq_op_e op
);
  always_comb begin
    if (stall)     op = OP_HOLD;
    else if (!adv) op = OP_LOAD;
    else           op = OP_STEP;
  end
endmodule

// File: rtl/bseq_state.sv
module bseq_state
  import bseq_pkg::*;
#(
  parameter int UPPER_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  seq_op_e            op,
  input  beat_t              ld_start,
  input  logic [UPPER_W-1:0] ld_upper,
  output beat_t              start_q,
  output beat_t              beat_q,
  output logic [UPPER_W-1:0] upper_q
);
  beat_t              start_d, beat_d;
  logic [UPPER_W-1:0] upper_d;
  logic               upd_en;

  always_comb begin
    start_d = start_q;
    beat_d  = beat_q;
    upper_d = upper_q;
    upd_en  = 1'b0;
    unique case (op)
      OP_LOAD: begin
        start_d = ld_start;
        beat_d  = '0;
        upper_d = ld_upper;
        upd_en  = 1'b1;
      end
      OP_STEP: begin
        beat_d = beat_q + beat_t'(1);
        upd_en = 1'b1;
      end
      default: upd_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      beat_q  <= '0;
      upper_q <= '0;
    end else if (upd_en) begin
      start_q <= start_d;
      beat_q  <= beat_d;
      upper_q <= upper_d;
    end
  end
endmodule

// File: rtl/bseq_order.sv
module bseq_order
  import bseq_pkg::*;
(
  input  logic  interleave,
  input  beat_t start,
  input  beat_t beat,
  output beat_t low
);
  beat_t xor_low, add_low;

  assign xor_low = start ^ beat;
  assign add_low = start + beat;
  assign low     = interleave ? xor_low : add_low;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bseq_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int SYNC_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall,
  input  logic              adv,
  input  logic              interleave,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] burst_addr
);
  localparam int UPPER_W = ADDR_W - BEAT_W;

  logic               rst_sync_n;
  seq_op_e            op;
  beat_t              start_q, beat_q, low;
  logic [UPPER_W-1:0] upper_q;

  bseq_rst_sync #(.STAGES(SYNC_STAGE)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  bseq_ctrl u_ctrl (
    .stall (stall),
    .adv   (adv),
    .op    (op)
  );

  bseq_state #(.UPPER_W(UPPER_W)) u_state (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .op       (op),
    .ld_start (ext_addr[BEAT_W-1:0]),
    .ld_upper (ext_addr[ADDR_W-1:BEAT_W]),
    .start_q  (start_q),
    .beat_q   (beat_q),
    .upper_q  (upper_q)
  );

  bseq_order u_order (
    .interleave (interleave),
    .start      (start_q),
    .beat       (beat_q),
    .low        (low)
  );

  assign burst_addr = {upper_q, low};
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              srst_n,
  input logic              stall,
  input logic              adv,
  input logic              interleave,
  input logic [ADDR_W-1:0] ext_addr,
  input logic [ADDR_W-1:0] burst_addr
);
  // R1
  reset_zero_chk: assert property (@(posedge clk)
    !srst_n |-> burst_addr == '0);

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (!stall && !adv) |=> burst_addr == $past(ext_addr));

  // R3
  interleave_toggle_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (!stall && adv && interleave) |=> burst_addr[0] != $past(burst_addr[0]));

  // R4
  linear_step_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (!stall && adv && !interleave) |=> burst_addr[1:0] == $past(burst_addr[1:0]) + 2'd1);

  // R5
  upper_keep_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (!stall && adv) |=> $stable(burst_addr[ADDR_W-1:2]));

  // R7
  stall_freeze_chk: assert property (@(posedge clk) disable iff (!srst_n)
    stall |=> $stable(burst_addr));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .srst_n     (rst_sync_n),
  .stall      (stall),
  .adv        (adv),
  .interleave (interleave),
  .ext_addr   (ext_addr),
  .burst_addr (burst_addr)
);

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;
  localparam int  ADDR_W  = 8;
  localparam time CLK_PER = 10ns;

  logic              clk = 1'b0;
  logic              rst_n, stall, adv, interleave;
  logic [ADDR_W-1:0] ext_addr;
  logic [ADDR_W-1:0] burst_addr;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  burst_addr_seq #(.ADDR_W(ADDR_W)) u_burst_addr_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .stall      (stall),
    .adv        (adv),
    .interleave (interleave),
    .ext_addr   (ext_addr),
    .burst_addr (burst_addr)
  );

  task automatic check(input string req, input logic [ADDR_W-1:0] exp);
    checks++;
    if (burst_addr !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, burst_addr, exp);
    end
  endtask

  function automatic logic [1:0] beat_low(input bit il, input logic [1:0] s, input logic [1:0] k);
    return il ? (s ^ k) : (s + k);
  endfunction

  // One edge with the given inputs; returns at the following negedge.
  task automatic cyc(input bit a, input bit s, input logic [ADDR_W-1:0] e);
    adv = a; stall = s; ext_addr = e;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; stall = 1'b1; adv = 1'b0; ext_addr = '1; interleave = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset", '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after release", '0);
  endtask

  task automatic t_burst(input bit il, input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] noise);
    interleave = il;
    cyc(1'b0, 1'b0, a);
    check("R2 load", a);
    for (int k = 1; k <= 4; k++) begin
      cyc(1'b1, 1'b0, noise);
      if (k == 4)
        check("R6 wrap", a);
      else
        check(il ? "R3 interleave R5" : "R4 linear R5",
              {a[ADDR_W-1:2], beat_low(il, a[1:0], 2'(k))});
    end
  endtask

  task automatic t_stall(input bit il, input logic [ADDR_W-1:0] a);
    interleave = il;
    cyc(1'b0, 1'b0, a);
    cyc(1'b1, 1'b0, a);
    for (int i = 0; i < 3; i++) begin
      cyc(i[0], 1'b1, ~a);
      check("R7 stall hold", {a[ADDR_W-1:2], beat_low(il, a[1:0], 2'd1)});
    end
    cyc(1'b1, 1'b0, ~a);
    check("R7 resume", {a[ADDR_W-1:2], beat_low(il, a[1:0], 2'd2)});
    cyc(1'b1, 1'b0, ~a);
    cyc(1'b1, 1'b0, ~a);
    check("R6 wrap after stall", a);
  endtask

  task automatic t_reload(input bit il, input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] b);
    interleave = il;
    cyc(1'b0, 1'b0, a);
    cyc(1'b1, 1'b0, b);
    cyc(1'b1, 1'b0, b);
    cyc(1'b0, 1'b0, b);
    check("R8 reload", b);
    cyc(1'b1, 1'b0, a);
    check("R8 new burst", {b[ADDR_W-1:2], beat_low(il, b[1:0], 2'd1)});
  endtask

  initial begin
    t_reset();
    for (int s = 0; s < 4; s++) begin
      t_burst(1'b1, 8'hA4 | 8'(s), 8'h5B);
      t_burst(1'b0, 8'h38 | 8'(s), 8'hC7);
    end
    t_stall(1'b1, 8'h6E);
    t_stall(1'b0, 8'h93);
    t_reload(1'b1, 8'h11, 8'hF2);
    t_reload(1'b0, 8'h47, 8'h2B);
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 5000 && !done; i++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule